// File: doc/BRIEF.md
# Bus-Clocked Wiper Stepper

This block runs the fine-tuning mode of a quad digital potentiometer controller attached to a two-wire serial bus. The protocol front end decodes the address and command bytes. Once it has acknowledged the step command for one wiper, it pulses `sess_start` and presents the wiper index on `sess_pot`. From then on the serial clock no longer frames bytes. Each clock-high pulse on the bus becomes one step of the chosen wiper. The level of the data line during that pulse sets the direction: high moves the wiper toward the high terminal, low moves it toward the low terminal. The session continues, with steps in either direction, until the master sends a stop condition.

Both bus lines are sampled into the system clock domain. The direction is captured when the synchronized clock rises. The step is committed when the synchronized clock falls, and only if the data line stayed steady for the whole high phase. Because of this, the pulse that carries a stop condition never moves the wiper. The register bank returns the current value of the addressed wiper on `wiper_now`. The block uses that value to suppress steps at either end of the range, so the wiper saturates instead of wrapping. The block never drives the bus and never requests a nonvolatile store. Its only effect is a one-cycle strobe per step to the volatile wiper register.

Top module: `wiper_stepper`

## Requirements
- R1: After reset `step_active` is 0 and `step_stb` is all zero.
- R2: While no session is open, bus clock pulses produce no strobe.
- R3: In a session, a clock-high pulse with data high produces one strobe for the selected wiper with `step_dir` = 1 (toward the high terminal, +1).
- R4: In a session, a clock-high pulse with data low produces one strobe with `step_dir` = 0 (toward the low terminal, -1).
- R5: Each pulse yields at most one single-cycle strobe, and at most one bit of `step_stb` (bit i = wiper i) is set at a time.
- R6: Up and down pulses may be mixed in one session, and each is applied in order.
- R7: No up strobe is issued while `wiper_now` is FFh, so the wiper stays at FFh.
- R8: No down strobe is issued while `wiper_now` is 00h, so the wiper stays at 00h.
- R9: A stop condition (data rising while the clock is high) closes the session and clears `step_active`, and its own clock pulse makes no step. Later pulses are ignored.
- R10: The wiper index is captured at `sess_start`. Changing `sess_pot` during a session does not change which wiper steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial bus clock |
| sda_in | input | 1 | Raw serial bus data level |
| sess_start | input | 1 | One-cycle pulse from the front end that opens a step session |
| sess_pot | input | 2 | Wiper index, captured at `sess_start` |
| wiper_now | input | 8 | Current value of the addressed wiper, from the register bank |
| step_stb | output | 4 | One-cycle step strobe, one bit per wiper |
| step_dir | output | 1 | Step direction: 1 = +1, 0 = -1 |
| step_active | output | 1 | A step session is open |

## Verification
The hardest case to reach from the ports is a stop condition inside an open session. Its clock pulse starts with the data line low, so it looks like a decrement until the data line rises in the middle of the high phase. The bench produces it by preloading a wiper to a known value, driving real steps, and then issuing a full stop pulse. It then confirms that the wiper did not lose a step, that `step_active` fell, and that later pulses move nothing. The end-of-range cases are reached by preloading the bank model to FEh and 01h, so that one legal step is followed by several suppressed ones.

// File: rtl/wiper_stepper_pkg.sv
package wiper_stepper_pkg;
    // Bus events seen in the system clock domain, one cycle wide each
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_lvl;
        logic sda_moved_hi;   // data changed while clock stayed high
        logic stop_seen;      // data rose while clock stayed high
    } bus_evt_t;
endpackage

// File: rtl/wst_sync.sv
module wst_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
    end

    // Idle bus lines are high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/wst_cond.sv
module wst_cond
    import wiper_stepper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
        evt.scl_rise     = scl_s & ~prev_q.scl;
        evt.scl_fall     = ~scl_s & prev_q.scl;
        evt.sda_lvl      = sda_s;
        evt.sda_moved_hi = scl_s & prev_q.scl & (sda_s ^ prev_q.sda);
        evt.stop_seen    = scl_s & prev_q.scl & sda_s & ~prev_q.sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/wst_core.sv
module wst_core
    import wiper_stepper_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int WIPER_W  = 8,
    localparam int PW      = $clog2(NUM_POTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_evt_t            evt,
    input  logic                sess_start,
    input  logic [PW-1:0]       sess_pot,
    input  logic [WIPER_W-1:0]  wiper_now,
    output logic [NUM_POTS-1:0] step_stb,
    output logic                step_dir,
    output logic                step_active,
    output logic [PW-1:0]       cur_pot
);
    localparam logic [WIPER_W-1:0] TOP = '1;
    localparam logic [WIPER_W-1:0] BOT = '0;

    typedef struct packed {
        logic                active;
        logic                armed;
        logic                dir;
        logic [PW-1:0]       pot;
        logic [NUM_POTS-1:0] stb;
    } core_t;

    core_t st_d, st_q;
    logic  room;

    always_comb begin
        st_d     = st_q;
        st_d.stb = '0;
        room     = st_q.dir ? (wiper_now != TOP) : (wiper_now != BOT);
        if (sess_start) begin
            st_d.active = 1'b1;
            st_d.armed  = 1'b0;
            st_d.pot    = sess_pot;
        end else if (st_q.active) begin
            if (evt.stop_seen) begin
                st_d.active = 1'b0;
                st_d.armed  = 1'b0;
            end else if (evt.sda_moved_hi) begin
                st_d.armed = 1'b0;
            end else if (evt.scl_rise) begin
                st_d.armed = 1'b1;
                st_d.dir   = evt.sda_lvl;
            end else if (evt.scl_fall && st_q.armed) begin
                st_d.armed = 1'b0;
                if (room) st_d.stb[st_q.pot] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_stb    = st_q.stb;
    assign step_dir    = st_q.dir;
    assign step_active = st_q.active;
    assign cur_pot     = st_q.pot;
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
    import wiper_stepper_pkg::*;
#(
    parameter int NUM_POTS    = 4,
    parameter int WIPER_W     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(NUM_POTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                sess_start,
    input  logic [PW-1:0]       sess_pot,
    input  logic [WIPER_W-1:0]  wiper_now,
    output logic [NUM_POTS-1:0] step_stb,
    output logic                step_dir,
    output logic                step_active
);
    logic [1:0]    bus_s;
    bus_evt_t      evt;
    logic [PW-1:0] cur_pot;

    wst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_in, sda_in}), .dout(bus_s)
    );

    wst_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .evt(evt)
    );

    wst_core #(.NUM_POTS(NUM_POTS), .WIPER_W(WIPER_W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .sess_start(sess_start), .sess_pot(sess_pot), .wiper_now(wiper_now),
        .step_stb(step_stb), .step_dir(step_dir), .step_active(step_active),
        .cur_pot(cur_pot)
    );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
    parameter int NUM_POTS = 4,
    parameter int WIPER_W  = 8,
    parameter int PW       = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sess_start,
    input logic [WIPER_W-1:0]  wiper_now,
    input logic [NUM_POTS-1:0] step_stb,
    input logic                step_dir,
    input logic                step_active,
    input logic [PW-1:0]       cur_pot
);
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_stb));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_stb != '0) |=> (step_stb == '0));

    a_r2_only_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        (step_stb != '0) |-> $past(step_active));

    a_r7_no_up_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_stb != '0) && step_dir) |-> ($past(wiper_now) != '1));

    a_r8_no_down_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_stb != '0) && !step_dir) |-> ($past(wiper_now) != '0));

    a_r10_pot_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sess_start) |-> $stable(cur_pot));
endmodule

bind wiper_stepper wiper_stepper_chk #(.NUM_POTS(NUM_POTS), .WIPER_W(WIPER_W), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .wiper_now(wiper_now),
    .step_stb(step_stb), .step_dir(step_dir), .step_active(step_active),
    .cur_pot(cur_pot)
);

// File: tb/wiper_stepper_test.sv
module wiper_stepper_test;
    localparam int HALF = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       scl_in = 1, sda_in = 1;
    logic       sess_start = 0;
    logic [1:0] sess_pot = 0;
    logic [7:0] wiper_now;
    logic [3:0] step_stb;
    logic       step_dir, step_active;

    logic [7:0] bank [4];
    logic [1:0] tb_sel = 0;
    int         stb_cnt = 0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    wiper_stepper uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sess_start(sess_start), .sess_pot(sess_pot), .wiper_now(wiper_now),
        .step_stb(step_stb), .step_dir(step_dir), .step_active(step_active)
    );

    // Register bank model: plain wrapping counters, so a missed saturation shows
    assign wiper_now = bank[tb_sel];
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (step_stb[i]) bank[i] <= step_dir ? bank[i] + 8'd1 : bank[i] - 8'd1;
        if (step_stb != 0) stb_cnt <= stb_cnt + 1;
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(int p, int v);
        @(negedge clk);
        bank[p] = v[7:0];
    endtask

    task automatic pulse(bit lvl);
        sda_in = lvl; wait_cyc(HALF);
        scl_in = 1;   wait_cyc(HALF);
        scl_in = 0;   wait_cyc(HALF);
    endtask

    task automatic open_session(int p);
        @(negedge clk);
        sess_pot = p[1:0]; sess_start = 1; tb_sel = p[1:0];
        @(negedge clk);
        sess_start = 0;
    endtask

    task automatic send_stop();
        sda_in = 0; wait_cyc(HALF);
        scl_in = 1; wait_cyc(HALF);
        sda_in = 1; wait_cyc(HALF);
        wait_cyc(4);
    endtask

    task automatic t_reset();
        check("R1 active", step_active, 0);
        check("R1 strobe", step_stb, 0);
    endtask

    task automatic t_idle();
        int c0 = stb_cnt;
        preload(0, 40);
        tb_sel = 0;
        pulse(1); pulse(0); pulse(1);
        check("R2 no strobes", stb_cnt - c0, 0);
        check("R2 wiper", bank[0], 40);
    endtask

    task automatic t_up();
        int c0;
        preload(1, 10); preload(2, 77);
        c0 = stb_cnt;
        open_session(1);
        check("R3 active", step_active, 1);
        repeat (3) pulse(1);
        check("R3 wiper up", bank[1], 13);
        check("R3 dir", step_dir, 1);
        check("R5 one strobe per pulse", stb_cnt - c0, 3);
        check("R5 other wiper", bank[2], 77);
        send_stop();
    endtask

    task automatic t_down();
        preload(2, 5);
        open_session(2);
        repeat (2) pulse(0);
        check("R4 wiper down", bank[2], 3);
        check("R4 dir", step_dir, 0);
        send_stop();
    endtask

    task automatic t_mix();
        preload(3, 100);
        open_session(3);
        pulse(1); pulse(1); pulse(0); pulse(1); pulse(0); pulse(0); pulse(0);
        check("R6 mixed", bank[3], 99);
        send_stop();
    endtask

    task automatic t_top();
        int c0;
        preload(0, 8'hFE);
        c0 = stb_cnt;
        open_session(0);
        repeat (3) pulse(1);
        check("R7 saturate high", bank[0], 255);
        check("R7 strobes", stb_cnt - c0, 1);
        send_stop();
    endtask

    task automatic t_bottom();
        preload(0, 1);
        open_session(0);
        repeat (3) pulse(0);
        check("R8 saturate low", bank[0], 0);
        send_stop();
    endtask

    task automatic t_stop();
        int c0;
        preload(1, 50);
        open_session(1);
        pulse(1);
        c0 = stb_cnt;
        send_stop();
        check("R9 stop pulse no step", stb_cnt - c0, 0);
        check("R9 value kept", bank[1], 51);
        check("R9 inactive", step_active, 0);
        scl_in = 0; wait_cyc(HALF);
        pulse(0); pulse(1);
        check("R9 after stop ignored", bank[1], 51);
    endtask

    task automatic t_lock();
        preload(1, 20); preload(2, 30);
        open_session(1);
        sess_pot = 2;
        pulse(1); pulse(1);
        check("R10 captured wiper", bank[1], 22);
        check("R10 other untouched", bank[2], 30);
        send_stop();
        scl_in = 0; wait_cyc(HALF);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) bank[i] = 0;
        wait_cyc(5);
        t_reset();
        rst_n = 1;
        wait_cyc(5);
        scl_in = 0;
        wait_cyc(HALF);
        t_idle();
        t_up();      scl_in = 0; wait_cyc(HALF);
        t_down();    scl_in = 0; wait_cyc(HALF);
        t_mix();     scl_in = 0; wait_cyc(HALF);
        t_top();     scl_in = 0; wait_cyc(HALF);
        t_bottom();  scl_in = 0; wait_cyc(HALF);
        t_stop();
        t_lock();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule